// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Threshold Status

This block holds the bytes a serial engine receives until software collects them through a 32-bit register interface. The engine offers one byte at a time on a valid/ready handshake. Each register read is a pop strobe. A pop removes up to four of the oldest bytes and presents them packed into one 32-bit word. If fewer than four bytes are stored, the pop returns all of them and fills the upper byte lanes with zeros.

A status word is driven at all times. It carries the number of stored bytes, an empty flag, a data-present flag and three level flags. The level flags tell the reader that a burst of 16, 32 or 64 bytes can be collected. A flush strobe discards the contents in one cycle. A pop while nothing is stored produces a one-cycle underrun event for an interrupt controller. Register decoding and the interrupt register are outside this block.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the queue is empty: status reads 0x800 (only bit 11 set), pushReady is 1, underrunEvt is 0 and popData is 0.
- R2: A byte is stored on a rising edge where pushValid and pushReady are both 1. pushReady is 0 while DEPTH (default 64) bytes are stored. A refused byte is not stored and leaves the count unchanged.
- R3: Status bit 0 is 1 when at least one byte is stored. Status bit 11 is 1 when no byte is stored.
- R4: Status bits 1, 2 and 3 are 1 when at least 16, 32 and 64 bytes are stored, respectively.
- R5: Status bits 10:4 hold the number of stored bytes as an unsigned value from 0 to 64.
- R6: popData carries the oldest stored byte in bits 7:0. The next oldest bytes follow in bits 15:8, 23:16 and 31:24. A pop on a rising edge removes min(4, count) bytes.
- R7: When fewer than four bytes are stored, the byte lanes of popData above the stored bytes read as zero.
- R8: A flushReq of 1 on a rising edge clears the contents and the count. The flush takes priority over a push or pop in the same cycle. pushReady is 0 while flushReq is 1.
- R9: A pop with no byte stored sets underrunEvt to 1 for exactly the cycle after that edge and leaves the contents unchanged. Any other cycle has underrunEvt at 0.
- R10: A push and a pop on the same edge give a new count of count + 1 - min(4, count).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Engine offers a byte |
| pushData | input | 8 | Offered byte |
| pushReady | output | 1 | Queue accepts the offered byte |
| popStrobe | input | 1 | Register read: remove up to four bytes |
| popData | output | 32 | Packed oldest bytes, unused lanes zero |
| flushReq | input | 1 | Discard all contents |
| status | output | 12 | Level flags, count and empty flag |
| underrunEvt | output | 1 | One-cycle pulse after a pop on empty |

## Verification
The assertions assume that the engine holds pushValid to the handshake and reads popData only in the cycle of a pop. They place no limit on pops or flushes: a pop may arrive on an empty queue and a flush may coincide with any traffic. The stimulus therefore mixes pops, pushes and flushes freely. It also runs phases that favour pushes, which bring the queue to every threshold and to full. This makes sure the refusal, level-flag and underrun properties are exercised rather than holding vacuously.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_LANES    = 4;
  localparam int unsigned RXQ_BYTE_W   = 8;
  localparam int unsigned RXQ_WORD_W   = RXQ_LANES * RXQ_BYTE_W;
  localparam int unsigned RXQ_NUM_W    = $clog2(RXQ_LANES + 1);
  localparam int unsigned RXQ_LEVELS   = 3;
  localparam int unsigned RXQ_LEVEL0   = 16;

  typedef struct packed {
    logic                 pushEn;
    logic                 popEn;
    logic [RXQ_NUM_W-1:0] popNum;
    logic                 flush;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              popStrobe,
  input  logic              flushReq,
  output logic              pushReady,
  output rxq_strobe_t       strobes,
  output logic [CNT_W-1:0]  count,
  output logic              underrunEvt
);
  logic             isFull;
  logic             isEmpty;
  logic [CNT_W-1:0] popCnt;

  always_comb begin
    isFull    = (count == CNT_W'(DEPTH));
    isEmpty   = (count == '0);
    pushReady = !isFull && !flushReq;
    if (count >= CNT_W'(RXQ_LANES)) popCnt = CNT_W'(RXQ_LANES);
    else                            popCnt = count;
    strobes.flush  = flushReq;
    strobes.pushEn = pushValid && pushReady;
    strobes.popEn  = popStrobe && !flushReq && !isEmpty;
    strobes.popNum = RXQ_NUM_W'(popCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count       <= '0;
      underrunEvt <= 1'b0;
    end else begin
      underrunEvt <= popStrobe && isEmpty;
      if (strobes.flush) count <= '0;
      else count <= count + CNT_W'(strobes.pushEn)
                          - (strobes.popEn ? popCnt : '0);
    end
  end
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rxq_strobe_t           strobes,
  input  logic [RXQ_BYTE_W-1:0] pushData,
  input  logic [CNT_W-1:0]      count,
  output logic [RXQ_WORD_W-1:0] popData
);
  logic [RXQ_BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]     wrPtr;
  logic [ADDR_W-1:0]     rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.pushEn) wrPtr <= wrPtr + 1'b1;
      if (strobes.popEn)  rdPtr <= rdPtr + ADDR_W'(strobes.popNum);
    end
  end

  for (genvar i = 0; i < RXQ_LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] laneAddr;
    assign laneAddr = rdPtr + ADDR_W'(i);
    assign popData[i*RXQ_BYTE_W +: RXQ_BYTE_W] =
      (count > CNT_W'(i)) ? mem[laneAddr] : '0;
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned STAT_W = CNT_W + 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pushValid,
  input  logic [RXQ_BYTE_W-1:0] pushData,
  output logic                  pushReady,
  input  logic                  popStrobe,
  output logic [RXQ_WORD_W-1:0] popData,
  input  logic                  flushReq,
  output logic [STAT_W-1:0]     status,
  output logic                  underrunEvt
);
  rxq_strobe_t      strobes;
  logic [CNT_W-1:0] count;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popStrobe(popStrobe),
    .flushReq(flushReq), .pushReady(pushReady), .strobes(strobes),
    .count(count), .underrunEvt(underrunEvt)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushData(pushData),
    .count(count), .popData(popData)
  );

  assign status[0]                = (count != '0);
  assign status[CNT_W+3:4]        = count;
  assign status[CNT_W+4]          = (count == '0);
  for (genvar k = 0; k < RXQ_LEVELS; k++) begin : g_level
    assign status[1+k] = (count >= CNT_W'(RXQ_LEVEL0 << k));
  end
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned STAT_W = CNT_W + 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  pushValid,
  input logic [RXQ_BYTE_W-1:0] pushData,
  input logic                  pushReady,
  input logic                  popStrobe,
  input logic [RXQ_WORD_W-1:0] popData,
  input logic                  flushReq,
  input logic [STAT_W-1:0]     status,
  input logic                  underrunEvt
);
  logic [CNT_W-1:0] cnt;
  assign cnt = status[CNT_W+3:4];

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  p_full_refuses_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(DEPTH)) |-> !pushReady);

  p_push_counts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushReady && !popStrobe && !flushReq) |=> (cnt == $past(cnt) + 1'b1));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> status[CNT_W+4]);

  p_flush_blocks_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !pushReady);

  p_underrun_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && status[CNT_W+4]) |=> underrunEvt);

  p_underrun_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(popStrobe && status[CNT_W+4]) |=> !underrunEvt);

  p_single_lane_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(1)) |-> (popData[RXQ_WORD_W-1:RXQ_BYTE_W] == '0));

  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status[CNT_W+4] && !pushValid && !flushReq) |=> status[CNT_W+4]);
endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rxq_fifo_tb.sv
`timescale 1ns/1ps
module rxq_fifo_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [7:0]  pushData = '0;
  logic        pushReady;
  logic        popStrobe = 1'b0;
  logic [31:0] popData;
  logic        flushReq = 1'b0;
  logic [11:0] status;
  logic        underrunEvt;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [7:0] mdl[$];
  bit expUnder = 0;

  always #4 clk = ~clk;

  rxq_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushReady(pushReady), .popStrobe(popStrobe), .popData(popData),
    .flushReq(flushReq), .status(status), .underrunEvt(underrunEvt)
  );

  function automatic logic [11:0] expStatus(int n);
    logic [11:0] s;
    s = '0;
    s[0] = (n >= 1);
    s[1] = (n >= 16);
    s[2] = (n >= 32);
    s[3] = (n >= 64);
    s[10:4] = 7'(n);
    s[11] = (n == 0);
    return s;
  endfunction

  function automatic logic [31:0] expWord();
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 4; i++)
      if (i < mdl.size()) w[i*8 +: 8] = mdl[i];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(bit pv, logic [7:0] pd, bit pop, bit fl);
    logic [11:0] es;
    bit accept;
    @(negedge clk);
    pushValid = pv; pushData = pd; popStrobe = pop; flushReq = fl;
    #1;
    es = expStatus(mdl.size());
    check("R3 present/empty flags", {30'd0, status[11], status[0]}, {30'd0, es[11], es[0]});
    check("R4 level flags", {29'd0, status[3:1]}, {29'd0, es[3:1]});
    check("R5 count field", {25'd0, status[10:4]}, {25'd0, es[10:4]});
    if (mdl.size() < 4) check("R7 zero upper lanes", popData, expWord());
    else                check("R6 packed order", popData, expWord());
    if (fl) check("R8 ready low on flush", {31'd0, pushReady}, 32'd0);
    else    check("R2 ready vs full", {31'd0, pushReady}, {31'd0, mdl.size() < DEPTH});
    check("R9 underrun pulse", {31'd0, underrunEvt}, {31'd0, expUnder});
    accept = pv && !fl && (mdl.size() < DEPTH);
    expUnder = pop && (mdl.size() == 0);
    if (fl) mdl.delete();
    else begin
      if (pop) begin
        int n;
        n = (mdl.size() < 4) ? mdl.size() : 4;
        for (int i = 0; i < n; i++) void'(mdl.pop_front());
      end
      if (accept) mdl.push_back(pd);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset status", {20'd0, status}, 32'h800);
    check("R1 reset ready", {31'd0, pushReady}, 32'd1);
    check("R1 reset underrun", {31'd0, underrunEvt}, 32'd0);
    check("R1 reset popData", popData, 32'd0);

    // R9 pop on empty, then check nothing changed
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    // partial pops: 1, 2, 3 bytes (R7)
    for (int n = 1; n <= 3; n++) begin
      for (int i = 0; i < n; i++) step(1, 8'(8'hA0 + i + n * 16), 0, 0);
      step(0, 0, 1, 0);
    end
    // fill past full to exercise R2 refusal and R4 thresholds
    for (int i = 0; i < DEPTH + 4; i++) step(1, 8'(i * 7 + 1), 0, 0);
    // R10 push with pop while full is refused, then with room
    step(1, 8'h55, 1, 0);
    step(1, 8'h66, 1, 0);
    // R10 same-edge push and pop with count 2
    step(1, 8'h11, 1, 1);
    step(1, 8'h21, 0, 0);
    step(1, 8'h22, 0, 0);
    step(1, 8'h23, 1, 0);
    step(0, 0, 0, 0);
    nChecks++;
    if (mdl.size() != 1) begin
      nFails++;
      $display("FAIL R10: actual %0d expected 1", mdl.size());
    end
    // R8 flush with pop and push together
    step(1, 8'h99, 1, 1);
    step(0, 0, 0, 0);

    // random phases
    void'($urandom(32'h1234_5678));
    for (int ph = 0; ph < 12; ph++) begin
      int pushPct;
      int popPct;
      pushPct = (ph % 3 == 0) ? 90 : ((ph % 3 == 1) ? 50 : 20);
      popPct  = (ph % 3 == 0) ? 10 : ((ph % 3 == 1) ? 40 : 70);
      for (int k = 0; k < 250; k++) begin
        bit pv;
        bit pp;
        bit fl;
        pv = ($urandom % 100) < pushPct;
        pp = ($urandom % 100) < popPct;
        fl = ($urandom % 200) == 0;
        step(pv, 8'($urandom), pp, fl);
      end
    end
    step(0, 0, 0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule